// File: doc/BRIEF.md
# Programmable Square-Wave Output Generator

This block turns a 32768 Hz reference waveform into a programmable square wave on a single output pin. The reference arrives as a level already in the system clock domain; the block finds its rising edges and counts them in one free-running binary divider. The taps of that divider give every selectable frequency. The same divider also supplies a one-cycle once-per-second pulse for a timekeeping core.

Software controls the block through one 8-bit control byte that can be written and read back. Bit 4 enables the wave. Bits 1:0 select one of four rates. Bit 7 gives the static pin level used while the wave is disabled. The other bits are not stored.

Top module: `sqwave_gen`

## Requirements
- R1: After reset the control byte reads 0x00, `wave_out` is low and `sec_tick` is low.
- R2: A write stores bits 7, 4, 1 and 0 of `ctrl_wdata`. `ctrl_rdata` returns those bits in the same positions, and bits 6, 5, 3 and 2 always read as 0.
- R3: While bit 4 is 0, `wave_out` holds the value of bit 7, with no transitions.
- R4: While bit 4 is 1, bits 1:0 select the output frequency. 00 gives reference/32768 (1 Hz), 01 gives reference/8 (4096 Hz), 10 gives reference/4 (8192 Hz) and 11 gives the reference itself (32768 Hz).
- R5: Each enabled rate has a 50% duty cycle. Over any whole number of output periods, the output is high for exactly half the clock cycles.
- R6: While bit 4 is 1, bit 7 has no effect on `wave_out`.
- R7: `sec_tick` is a single-cycle pulse. It occurs once for every 32768 reference rising edges, and only in the cycle after a reference rising edge.
- R8: Changing the rate selection never restarts the divider. The 1 Hz phase, and the timing of `sec_tick`, continue undisturbed.
- R9: With rate 11 enabled, `wave_out` copies the reference level two clock cycles after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_phase | input | 1 | 32768 Hz reference level, synchronous to clk |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| ctrl_rdata | output | 8 | Control byte read value, reserved bits zero |
| wave_out | output | 1 | Square-wave or static output pin value |
| sec_tick | output | 1 | One-cycle pulse per 32768 reference edges |

## Verification
A control write can land in the same cycle as a divider step, including the step that wraps the divider and raises `sec_tick`. The directed part of the bench provokes this case. It waits for one `sec_tick` and then rewrites the rate selection several times within the following half second, while reference edges keep arriving. It then checks that the 1 Hz output is still low, and that its rising edge comes 32769 cycles after the tick, which is the same point it would reach if no rate writes had occurred. The vector table checks each control value separately by counting high cycles and rising edges over a fixed window.

// File: rtl/sqwave_pkg.sv
package sqwave_pkg;

    localparam int CTRL_W   = 8;
    localparam int BIT_LVL  = 7;
    localparam int BIT_EN   = 4;
    localparam int NUM_RATE = 4;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'b00,
        RATE_MID  = 2'b01,
        RATE_HIGH = 2'b10,
        RATE_REF  = 2'b11
    } rate_e;

    typedef struct packed {
        logic  idle_lvl;
        logic  wave_en;
        rate_e rate;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{idle_lvl: 1'b0, wave_en: 1'b0, rate: RATE_SLOW};

    function automatic ctrl_t ctrl_from_byte(input logic [CTRL_W-1:0] b);
        ctrl_t c;
        c.idle_lvl = b[BIT_LVL];
        c.wave_en  = b[BIT_EN];
        c.rate     = rate_e'(b[1:0]);
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_to_byte(input ctrl_t c);
        logic [CTRL_W-1:0] b;
        b          = '0;
        b[BIT_LVL] = c.idle_lvl;
        b[BIT_EN]  = c.wave_en;
        b[1:0]     = c.rate;
        return b;
    endfunction

endpackage

// File: rtl/sqwave_ctrl_reg.sv
module sqwave_ctrl_reg
    import sqwave_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [CTRL_W-1:0] rd_data
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = ctrl_from_byte(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl    = ctrl_q;
    assign rd_data = ctrl_to_byte(ctrl_q);

endmodule

// File: rtl/sqwave_divider.sv
module sqwave_divider
    import sqwave_pkg::*;
#(
    parameter int DIV_W     = 15,
    parameter int MID_LOG2  = 12,
    parameter int HIGH_LOG2 = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_phase,
    output logic [NUM_RATE-1:0] taps,
    output logic                sec_tick
);

    localparam int TAP_SLOW = DIV_W - 1;
    localparam int TAP_MID  = DIV_W - MID_LOG2 - 1;
    localparam int TAP_HIGH = DIV_W - HIGH_LOG2 - 1;
    localparam logic [DIV_W-1:0] CNT_LAST = '1;

    typedef struct packed {
        logic             ref_s;
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       ref_rise;

    assign ref_rise = ref_phase & ~st_q.ref_s;

    always_comb begin
        st_d       = st_q;
        st_d.ref_s = ref_phase;
        st_d.tick  = 1'b0;
        if (ref_rise) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = (st_q.cnt == CNT_LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    function automatic int tap_index(input int sel);
        case (sel)
            0:       return TAP_SLOW;
            1:       return TAP_MID;
            default: return TAP_HIGH;
        endcase
    endfunction

    for (genvar g = 0; g < NUM_RATE; g++) begin : g_tap
        if (g == int'(RATE_REF)) begin : g_ref
            assign taps[g] = st_q.ref_s;
        end else begin : g_div
            assign taps[g] = st_q.cnt[tap_index(g)];
        end
    end

    assign sec_tick = st_q.tick;

endmodule

// File: rtl/sqwave_out_mux.sv
module sqwave_out_mux
    import sqwave_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  ctrl_t               ctrl,
    input  logic [NUM_RATE-1:0] taps,
    output logic                pin
);

    typedef struct packed {
        logic pin;
    } mux_state_t;

    mux_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl.wave_en) begin
            st_d.pin = taps[ctrl.rate];
        end else begin
            st_d.pin = ctrl.idle_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin = st_q.pin;

endmodule

// File: rtl/sqwave_gen.sv
module sqwave_gen
    import sqwave_pkg::*;
#(
    parameter int DIV_W     = 15,
    parameter int MID_LOG2  = 12,
    parameter int HIGH_LOG2 = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_phase,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic              wave_out,
    output logic              sec_tick
);

    ctrl_t               ctrl;
    logic [NUM_RATE-1:0] taps;

    sqwave_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_we),
        .wr_data (ctrl_wdata),
        .ctrl    (ctrl),
        .rd_data (ctrl_rdata)
    );

    sqwave_divider #(
        .DIV_W     (DIV_W),
        .MID_LOG2  (MID_LOG2),
        .HIGH_LOG2 (HIGH_LOG2)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_phase (ref_phase),
        .taps      (taps),
        .sec_tick  (sec_tick)
    );

    sqwave_out_mux u_mux (
        .clk   (clk),
        .rst_n (rst_n),
        .ctrl  (ctrl),
        .taps  (taps),
        .pin   (wave_out)
    );

endmodule

// File: rtl/sqwave_gen_chk.sv
module sqwave_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_phase,
    input logic [7:0] ctrl_rdata,
    input logic       wave_out,
    input logic       sec_tick
);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata & 8'h6C) == 8'h00);

    assert_static_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl_rdata[4]) |-> (wave_out == $past(ctrl_rdata[7])));

    assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    assert_tick_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> ($past(ref_phase) && !$past(ref_phase, 2)));

    assert_ref_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_rdata[4]) && $past(ctrl_rdata[1:0]) == 2'b11)
            |-> (wave_out == $past(ref_phase, 2)));

endmodule

bind sqwave_gen sqwave_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_phase  (ref_phase),
    .ctrl_rdata (ctrl_rdata),
    .wave_out   (wave_out),
    .sec_tick   (sec_tick)
);

// File: tb/sqwave_gen_bench.sv
`timescale 1ns/1ps
module sqwave_gen_bench;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] hi;
        logic [15:0] rise;
    } vec_t;

    localparam int NVEC = 9;
    localparam int WIN  = 256;
    localparam vec_t VECS [NVEC] = '{
        '{8'h11, 16'd128, 16'd16},
        '{8'h12, 16'd128, 16'd32},
        '{8'h13, 16'd128, 16'd128},
        '{8'h80, 16'd256, 16'd0},
        '{8'h00, 16'd0,   16'd0},
        '{8'h93, 16'd128, 16'd128},
        '{8'h6C, 16'd0,   16'd0},
        '{8'hFF, 16'd128, 16'd128},
        '{8'h91, 16'd128, 16'd16}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_phase = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [7:0] ctrl_rdata;
    logic       wave_out;
    logic       sec_tick;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        ref_phase <= ~ref_phase;
    end

    sqwave_gen u_sqwave_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_phase  (ref_phase),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .wave_out   (wave_out),
        .sec_tick   (sec_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] b);
        @(negedge clk);
        ctrl_we    = 1'b1;
        ctrl_wdata = b;
        @(negedge clk);
        ctrl_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (196000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hi;
        int rises;
        int ticks;
        int t_b;
        logic prev;

        idle(4);
        // R1: outputs held during reset
        check("R1 rdata in reset", ctrl_rdata, 0);
        check("R1 wave in reset", wave_out, 0);
        check("R1 tick in reset", sec_tick, 0);
        rst_n = 1'b1;
        idle(6);
        check("R1 rdata after reset", ctrl_rdata, 0);
        check("R1 wave after reset", wave_out, 0);

        // Vector table: R2 readback, R3/R6 static or ignored level, R4/R5/R9 rates
        for (int v = 0; v < NVEC; v++) begin
            write_ctrl(VECS[v].ctrl);
            check("R2 readback", ctrl_rdata, int'(VECS[v].ctrl & 8'h93));
            idle(8);
            hi    = 0;
            rises = 0;
            prev  = wave_out;
            for (int i = 0; i < WIN; i++) begin
                @(negedge clk);
                if (wave_out) hi++;
                if (wave_out && !prev) rises++;
                prev = wave_out;
            end
            check("R3/R5/R6 high cycles", hi, int'(VECS[v].hi));
            check("R4/R9 rising edges", rises, int'(VECS[v].rise));
        end

        // R7: 1 Hz output and second pulse over one full period
        write_ctrl(8'h10);
        while (!sec_tick) @(negedge clk);
        hi    = 0;
        rises = 0;
        ticks = 0;
        prev  = wave_out;
        t_b   = 0;
        for (int i = 0; i < 65536; i++) begin
            @(negedge clk);
            if (wave_out) hi++;
            if (wave_out && !prev) rises++;
            if (sec_tick) begin
                ticks++;
                t_b = cyc;
            end
            prev = wave_out;
        end
        check("R5 1Hz high cycles", hi, 32768);
        check("R4 1Hz rising edges", rises, 1);
        check("R7 ticks per second", ticks, 1);
        check("R7 tick at period end", sec_tick, 1);

        // R8: rate writes right after the tick leave the 1 Hz phase intact
        write_ctrl(8'h13);
        idle(200);
        write_ctrl(8'h11);
        idle(200);
        write_ctrl(8'h10);
        idle(10);
        check("R8 1Hz still low", wave_out, 0);
        while (!wave_out) @(negedge clk);
        check("R8 1Hz rise offset", cyc - t_b, 32769);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule